// File: doc/BRIEF.md
# Floating-Point Register Stack Manager

This block holds eight 80-bit extended-precision registers and the bookkeeping that lets an execution unit use them as a circular stack. A 3-bit top pointer selects which physical register is the stack top, and stack-relative slot ST(i) resolves to physical register (top + i) mod 8. Each register carries a 2-bit tag that the block derives from the stored value, so the tag always agrees with the contents. The block performs the stack operations, push, pop, two-result push, stack-relative read and write, a tag-word restore and a full initialisation. Arithmetic, rounding and instruction decode stay outside.

A push into an occupied slot is a stack overflow. A read or pop of an empty slot is a stack underflow. Either one pulses an invalid-operation strobe together with a separate stack-fault strobe, and a direction bit records which case occurred. When the caller marks the invalid fault as masked, the stack operation still completes and a quiet NaN replaces the data. When the fault is unmasked, the register state stays as it was.

Top module: `fp_regstack`

## Requirements
- R1: After reset or an INIT operation (opCode 7), topPtr is 0, tagWord is 16'hFFFF (every tag 11 = empty) and both fault strobes are low. Physical register p owns tagWord bits [2p+1:2p].
- R2: PUSH (opCode 1) into an empty target decrements topPtr modulo 8 and stores wrDataA in the new top. All outputs are registered: tagWord, topPtr, rdData and the strobes show the effect of an operation in the cycle after the edge that accepts it.
- R3: A stored value is tagged 01 (zero) when the exponent field [78:64] and the significand [63:0] are both zero. It is tagged 10 (special) when the exponent is all ones, or zero with a nonzero significand, or when the integer bit 63 is clear. Every other value is tagged 00 (valid).
- R4: READ (opCode 3) returns physical register (topPtr + stIdx) mod 8 on rdData. WRITE (opCode 4) stores wrDataA there and re-derives its tag. rdData changes only on READ.
- R5: POP (opCode 2) of a non-empty top sets that register's tag to 11 and increments topPtr modulo 8.
- R6: PUSH when physical register (topPtr-1) mod 8 is not empty pulses invalidFault and stackFault for one cycle and sets faultDir to 1. If invMask=0, topPtr and tagWord do not change. If invMask=1, topPtr decrements and the new top holds the quiet NaN 80'hFFFF_C000_0000_0000_0000 with tag 10.
- R7: READ or POP of an empty slot pulses invalidFault and stackFault and sets faultDir to 0. A READ of an empty slot returns the quiet NaN. A masked POP of an empty slot still increments topPtr. An unmasked one leaves the state unchanged. stackFault is never high without invalidFault.
- R8: PUSH2 (opCode 5) without overflow writes wrDataA into the current top, then decrements topPtr and writes wrDataB into the new top. Afterwards ST(1) holds wrDataA and ST(0) holds wrDataB.
- R9: PUSH2 that overflows pulses the same faults as R6. If masked, topPtr decrements and both ST(0) and ST(1) hold the quiet NaN. If unmasked, nothing changes.
- R10: RESTORE (opCode 6) takes tagIn (same field layout as tagWord). A field of 11 makes that register empty. Any other field is replaced by the tag derived from that register's contents per R3. Other state is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation accepted on this edge |
| opCode | input | 3 | 0 NOP, 1 PUSH, 2 POP, 3 READ, 4 WRITE, 5 PUSH2, 6 RESTORE, 7 INIT |
| stIdx | input | 3 | Stack-relative index i for READ and WRITE |
| wrDataA | input | 80 | Data for PUSH and WRITE; first result of PUSH2 |
| wrDataB | input | 80 | Second result of PUSH2 (becomes the new top) |
| tagIn | input | 16 | Tag word supplied to RESTORE |
| invMask | input | 1 | 1 when the invalid-operation fault is masked |
| rdData | output | 80 | Registered result of the last READ |
| topPtr | output | 3 | Physical index of the stack top |
| tagWord | output | 16 | Tags of all eight physical registers |
| invalidFault | output | 1 | One-cycle invalid-operation strobe |
| stackFault | output | 1 | One-cycle stack overflow/underflow strobe |
| faultDir | output | 1 | Direction of the last stack fault: 1 overflow, 0 underflow |

## Verification
The bench fills the stack until the pointer wraps from 0 to 7. It then pushes into the occupied slot with the fault masked and again unmasked. A design that tested the wrong neighbour would miss the overflow, and one that ignored the mask would either corrupt the stack or fail to substitute a NaN. The two-result push is checked when it succeeds, when it overflows masked (both slots must turn to NaN) and when it overflows unmasked (nothing may move). Reads and pops of empty slots must return a NaN and report underflow with the right direction. A restore that claims non-empty tags must be answered with tags derived from the actual contents, which exposes a design that copies tagIn verbatim.

// File: rtl/fp_regstack_pkg.sv
package fp_regstack_pkg;
  localparam int PTR_W = 3;
  localparam int NREG  = 1 << PTR_W;
  localparam int TAG_W = 2;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_PUSH    = 3'd1,
    OP_POP     = 3'd2,
    OP_READ    = 3'd3,
    OP_WRITE   = 3'd4,
    OP_PUSH2   = 3'd5,
    OP_RESTORE = 3'd6,
    OP_INIT    = 3'd7
  } opKind_e;

  localparam logic [TAG_W-1:0] TAG_VALID   = 2'b00;
  localparam logic [TAG_W-1:0] TAG_ZERO    = 2'b01;
  localparam logic [TAG_W-1:0] TAG_SPECIAL = 2'b10;
  localparam logic [TAG_W-1:0] TAG_EMPTY   = 2'b11;

  typedef enum logic [1:0] {
    SRC_A   = 2'd0,
    SRC_B   = 2'd1,
    SRC_NAN = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic             wrAEn;
    logic [PTR_W-1:0] wrAIdx;
    srcSel_e          wrASrc;
    logic             wrBEn;
    logic [PTR_W-1:0] wrBIdx;
    srcSel_e          wrBSrc;
    logic             clrEn;
    logic [PTR_W-1:0] clrIdx;
    logic             restoreEn;
    logic             initEn;
    logic             rdEn;
    logic [PTR_W-1:0] rdIdx;
    logic             rdNan;
  } ctrlStrobes_t;
endpackage

// File: rtl/fp_regstack_ctrl.sv
module fp_regstack_ctrl
  import fp_regstack_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [2:0]            opCode,
  input  logic [PTR_W-1:0]      stIdx,
  input  logic                  invMask,
  input  logic [TAG_W*NREG-1:0] tagWord,
  output ctrlStrobes_t          strb,
  output logic [PTR_W-1:0]      topPtr,
  output logic                  invalidFault,
  output logic                  stackFault,
  output logic                  faultDir
);
  opKind_e          opKind;
  logic [PTR_W-1:0] topDn, topUp, stPhys, topNext;
  logic             faultNow, dirNow;

  function automatic logic isEmpty(input logic [TAG_W*NREG-1:0] tw,
                                   input logic [PTR_W-1:0] idx);
    return tw[TAG_W*idx +: TAG_W] == TAG_EMPTY;
  endfunction

  assign opKind = opKind_e'(opCode);
  assign topDn  = topPtr - PTR_W'(1);
  assign topUp  = topPtr + PTR_W'(1);
  assign stPhys = topPtr + stIdx;

  always_comb begin
    strb     = '0;
    topNext  = topPtr;
    faultNow = 1'b0;
    dirNow   = faultDir;
    if (opValid) begin
      unique case (opKind)
        OP_PUSH, OP_PUSH2: begin
          if (!isEmpty(tagWord, topDn)) begin
            faultNow = 1'b1;
            dirNow   = 1'b1;
          end
          if (isEmpty(tagWord, topDn) || invMask) begin
            topNext     = topDn;
            strb.wrBEn  = 1'b1;
            strb.wrBIdx = topDn;
            strb.wrBSrc = faultNow ? SRC_NAN : (opKind == OP_PUSH2 ? SRC_B : SRC_A);
            if (opKind == OP_PUSH2) begin
              strb.wrAEn  = 1'b1;
              strb.wrAIdx = topPtr;
              strb.wrASrc = faultNow ? SRC_NAN : SRC_A;
            end
          end
        end
        OP_POP: begin
          if (isEmpty(tagWord, topPtr)) begin
            faultNow = 1'b1;
            dirNow   = 1'b0;
            if (invMask) topNext = topUp;
          end else begin
            strb.clrEn  = 1'b1;
            strb.clrIdx = topPtr;
            topNext     = topUp;
          end
        end
        OP_READ: begin
          strb.rdEn  = 1'b1;
          strb.rdIdx = stPhys;
          strb.rdNan = isEmpty(tagWord, stPhys);
          if (strb.rdNan) begin
            faultNow = 1'b1;
            dirNow   = 1'b0;
          end
        end
        OP_WRITE: begin
          strb.wrAEn  = 1'b1;
          strb.wrAIdx = stPhys;
          strb.wrASrc = SRC_A;
        end
        OP_RESTORE: strb.restoreEn = 1'b1;
        OP_INIT: begin
          strb.initEn = 1'b1;
          topNext     = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topPtr       <= '0;
      invalidFault <= 1'b0;
      stackFault   <= 1'b0;
      faultDir     <= 1'b0;
    end else begin
      topPtr       <= topNext;
      invalidFault <= faultNow;
      stackFault   <= faultNow;
      faultDir     <= dirNow;
    end
  end
endmodule

// File: rtl/fp_regstack_dp.sv
module fp_regstack_dp
  import fp_regstack_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int EXP_W  = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strb,
  input  logic [DATA_W-1:0]     wrDataA,
  input  logic [DATA_W-1:0]     wrDataB,
  input  logic [TAG_W*NREG-1:0] tagIn,
  output logic [DATA_W-1:0]     rdData,
  output logic [TAG_W*NREG-1:0] tagWord
);
  localparam int SIG_W = DATA_W - 1 - EXP_W;
  localparam logic [DATA_W-1:0] QNAN = {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  logic [DATA_W-1:0]     regQ [NREG];
  logic [TAG_W*NREG-1:0] tagNext;
  logic [TAG_W-1:0]      curCls [NREG];
  logic [DATA_W-1:0]     wrAVal, wrBVal;

  function automatic logic [TAG_W-1:0] classify(input logic [DATA_W-1:0] v);
    logic [EXP_W-1:0] e;
    logic [SIG_W-1:0] s;
    e = v[DATA_W-2 -: EXP_W];
    s = v[SIG_W-1:0];
    if (e == '0)       return (s == '0) ? TAG_ZERO : TAG_SPECIAL;
    else if (&e)       return TAG_SPECIAL;
    else if (!s[SIG_W-1]) return TAG_SPECIAL;
    else               return TAG_VALID;
  endfunction

  function automatic logic [DATA_W-1:0] pick(input srcSel_e sel,
                                             input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    unique case (sel)
      SRC_A:   return a;
      SRC_B:   return b;
      default: return QNAN;
    endcase
  endfunction

  assign wrAVal = pick(strb.wrASrc, wrDataA, wrDataB);
  assign wrBVal = pick(strb.wrBSrc, wrDataA, wrDataB);

  for (genvar g = 0; g < NREG; g++) begin : g_cls
    assign curCls[g] = classify(regQ[g]);
  end

  always_comb begin
    tagNext = tagWord;
    for (int p = 0; p < NREG; p++) begin
      if (strb.initEn)
        tagNext[TAG_W*p +: TAG_W] = TAG_EMPTY;
      else if (strb.wrAEn && strb.wrAIdx == PTR_W'(p))
        tagNext[TAG_W*p +: TAG_W] = classify(wrAVal);
      else if (strb.wrBEn && strb.wrBIdx == PTR_W'(p))
        tagNext[TAG_W*p +: TAG_W] = classify(wrBVal);
      else if (strb.clrEn && strb.clrIdx == PTR_W'(p))
        tagNext[TAG_W*p +: TAG_W] = TAG_EMPTY;
      else if (strb.restoreEn)
        tagNext[TAG_W*p +: TAG_W] =
          (tagIn[TAG_W*p +: TAG_W] == TAG_EMPTY) ? TAG_EMPTY : curCls[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagWord <= '1;
      rdData  <= '0;
    end else begin
      tagWord <= tagNext;
      if (strb.rdEn) rdData <= strb.rdNan ? QNAN : regQ[strb.rdIdx];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NREG; p++) begin
      if (strb.wrAEn && strb.wrAIdx == PTR_W'(p))      regQ[p] <= wrAVal;
      else if (strb.wrBEn && strb.wrBIdx == PTR_W'(p)) regQ[p] <= wrBVal;
    end
  end
endmodule

// File: rtl/fp_regstack.sv
module fp_regstack
  import fp_regstack_pkg::*;
#(
  parameter int DATA_W = 80,
  parameter int EXP_W  = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [2:0]            opCode,
  input  logic [PTR_W-1:0]      stIdx,
  input  logic [DATA_W-1:0]     wrDataA,
  input  logic [DATA_W-1:0]     wrDataB,
  input  logic [TAG_W*NREG-1:0] tagIn,
  input  logic                  invMask,
  output logic [DATA_W-1:0]     rdData,
  output logic [PTR_W-1:0]      topPtr,
  output logic [TAG_W*NREG-1:0] tagWord,
  output logic                  invalidFault,
  output logic                  stackFault,
  output logic                  faultDir
);
  ctrlStrobes_t strb;

  fp_regstack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .stIdx(stIdx), .invMask(invMask), .tagWord(tagWord), .strb(strb),
    .topPtr(topPtr), .invalidFault(invalidFault), .stackFault(stackFault),
    .faultDir(faultDir)
  );

  fp_regstack_dp #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrDataA(wrDataA),
    .wrDataB(wrDataB), .tagIn(tagIn), .rdData(rdData), .tagWord(tagWord)
  );
endmodule

// File: rtl/fp_regstack_chk.sv
module fp_regstack_chk
  import fp_regstack_pkg::*;
#(
  parameter int DATA_W = 80
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  opValid,
  input logic [2:0]            opCode,
  input logic                  invMask,
  input logic [TAG_W*NREG-1:0] tagIn,
  input logic [DATA_W-1:0]     rdData,
  input logic [PTR_W-1:0]      topPtr,
  input logic [TAG_W*NREG-1:0] tagWord,
  input logic                  invalidFault,
  input logic                  stackFault,
  input logic                  faultDir
);
  logic [PTR_W-1:0] belowTop;
  logic             belowFull, topEmpty, isPush, isPop, isInit, isRestore;

  assign belowTop  = topPtr - PTR_W'(1);
  assign belowFull = tagWord[TAG_W*belowTop +: TAG_W] != TAG_EMPTY;
  assign topEmpty  = tagWord[TAG_W*topPtr +: TAG_W] == TAG_EMPTY;
  assign isPush    = opValid && (opCode == OP_PUSH || opCode == OP_PUSH2);
  assign isPop     = opValid && opCode == OP_POP;
  assign isInit    = opValid && opCode == OP_INIT;
  assign isRestore = opValid && opCode == OP_RESTORE;

  p_init_r1: assert property (@(posedge clk) disable iff (!rstN)
    isInit |=> (topPtr == '0) && (tagWord == '1));

  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (isPush && !belowFull) |=> topPtr == $past(topPtr) - PTR_W'(1));

  p_pop_inc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isPop && !topEmpty) |=> topPtr == $past(topPtr) + PTR_W'(1));

  p_ovf_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isPush && belowFull) |=> invalidFault && stackFault && faultDir);

  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (isPush && belowFull && !invMask) |=> $stable(topPtr) && $stable(tagWord));

  p_unf_dir_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isPop && topEmpty) |=> stackFault && !faultDir);

  p_stk_inv_r7: assert property (@(posedge clk) disable iff (!rstN)
    stackFault |-> invalidFault);

  p_restore_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    (isRestore && tagIn == '1) |=> tagWord == '1 && $stable(topPtr) && $stable(rdData));
endmodule

bind fp_regstack fp_regstack_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .invMask(invMask), .tagIn(tagIn), .rdData(rdData), .topPtr(topPtr),
  .tagWord(tagWord), .invalidFault(invalidFault), .stackFault(stackFault),
  .faultDir(faultDir)
);

// File: tb/fp_regstack_tb.sv
module fp_regstack_tb;
  localparam logic [79:0] NAN = 80'hFFFF_C000_0000_0000_0000;

  logic        clk = 0, rstN = 0, opValid = 0, invMask = 0;
  logic [2:0]  opCode = 0, stIdx = 0;
  logic [79:0] wrDataA = 0, wrDataB = 0;
  logic [15:0] tagIn = 0;
  logic [79:0] rdData;
  logic [2:0]  topPtr;
  logic [15:0] tagWord;
  logic        invalidFault, stackFault, faultDir;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  fp_regstack u_dut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          at;
    string       req;
    logic [2:0]  top;
    logic [15:0] tags;
    logic [79:0] rd;
    bit          chkRd;
    logic        flt;
    logic        dir;
  } item_t;
  item_t sbq[$];

  logic [79:0] mReg [8];
  logic [1:0]  mTag [8];
  logic [2:0]  mTop = 0;
  logic        mDir = 0;

  function automatic logic [1:0] cls(input logic [79:0] v);
    if (v[78:64] == 0) return (v[63:0] == 0) ? 2'b01 : 2'b10;
    if (&v[78:64]) return 2'b10;
    if (!v[63]) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [15:0] packTags();
    logic [15:0] t;
    for (int p = 0; p < 8; p++) t[2*p +: 2] = mTag[p];
    return t;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [2:0] idx,
                      input logic [79:0] a, input logic [79:0] b,
                      input logic msk, input logic [15:0] tin, input string req);
    item_t it;
    logic [2:0] dn, ph;
    logic flt;
    it.chkRd = 0; it.rd = 0; flt = 0;
    dn = mTop - 3'd1;
    ph = mTop + idx;
    case (op)
      3'd1, 3'd5: begin
        flt = (mTag[dn] != 2'b11);
        if (flt) mDir = 1;
        if (!flt || msk) begin
          if (op == 3'd5) begin
            mReg[mTop] = flt ? NAN : a; mTag[mTop] = cls(mReg[mTop]);
            mReg[dn] = flt ? NAN : b;
          end else mReg[dn] = flt ? NAN : a;
          mTag[dn] = cls(mReg[dn]);
          mTop = dn;
        end
      end
      3'd2: begin
        flt = (mTag[mTop] == 2'b11);
        if (flt) mDir = 0; else mTag[mTop] = 2'b11;
        if (!flt || msk) mTop = mTop + 3'd1;
      end
      3'd3: begin
        flt = (mTag[ph] == 2'b11);
        if (flt) mDir = 0;
        it.chkRd = 1; it.rd = flt ? NAN : mReg[ph];
      end
      3'd4: begin mReg[ph] = a; mTag[ph] = cls(a); end
      3'd6: for (int p = 0; p < 8; p++)
              mTag[p] = (tin[2*p +: 2] == 2'b11) ? 2'b11 : cls(mReg[p]);
      3'd7: begin mTop = 0; for (int p = 0; p < 8; p++) mTag[p] = 2'b11; end
      default: ;
    endcase
    @(posedge clk); #1;
    opValid = 1; opCode = op; stIdx = idx; wrDataA = a; wrDataB = b;
    invMask = msk; tagIn = tin;
    it.at = cyc; it.req = req; it.top = mTop; it.tags = packTags();
    it.flt = flt; it.dir = mDir;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1; opValid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0 && sbq[0].at + 1 == cyc) begin
      item_t it;
      it = sbq.pop_front();
      check(it.req, "topPtr", 80'(topPtr), 80'(it.top));
      check(it.req, "tagWord", 80'(tagWord), 80'(it.tags));
      check(it.req, "invalidFault", 80'(invalidFault), 80'(it.flt));
      check(it.req, "stackFault", 80'(stackFault), 80'(it.flt));
      check(it.req, "faultDir", 80'(faultDir), 80'(it.dir));
      if (it.chkRd) check(it.req, "rdData", rdData, it.rd);
    end
  end

  localparam logic [79:0] V1 = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] V2 = 80'hC001_A000_0000_0000_1234;
  localparam logic [79:0] V3 = 80'h4005_F000_0000_0000_0001;
  localparam logic [79:0] V4 = 80'h3FFE_C000_0000_0000_0000;
  localparam logic [79:0] ZR = 80'h0;
  localparam logic [79:0] DN = 80'h0000_0000_0000_0000_0001;
  localparam logic [79:0] UN = 80'h4000_4000_0000_0000_0000;

  initial begin
    for (int p = 0; p < 8; p++) begin mTag[p] = 2'b11; mReg[p] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset topPtr", 80'(topPtr), 80'd0);
    check("R1", "reset tagWord", 80'(tagWord), 80'hFFFF);
    check("R1", "reset faults", 80'({invalidFault, stackFault}), 80'd0);
    // R2 R3 pushes of valid, zero, denormal
    doOp(3'd1, 0, V1, 0, 0, 0, "R2");
    doOp(3'd1, 0, ZR, 0, 0, 0, "R3");
    doOp(3'd1, 0, DN, 0, 0, 0, "R3");
    // R4 stack-relative reads and write
    doOp(3'd3, 0, 0, 0, 0, 0, "R4");
    doOp(3'd3, 2, 0, 0, 0, 0, "R4");
    doOp(3'd4, 1, V2, 0, 0, 0, "R4");
    doOp(3'd3, 1, 0, 0, 0, 0, "R4");
    doOp(3'd4, 2, UN, 0, 0, 0, "R3");
    // R7 read of empty slot (phys 0)
    doOp(3'd3, 3, 0, 0, 0, 0, "R7");
    // R5 pop
    doOp(3'd2, 0, 0, 0, 0, 0, "R5");
    // R8 two-result push
    doOp(3'd5, 0, V3, V4, 0, 0, "R8");
    doOp(3'd3, 0, 0, 0, 0, 0, "R8");
    doOp(3'd3, 1, 0, 0, 0, 0, "R8");
    // fill to wrap
    doOp(3'd1, 0, V1, 0, 0, 0, "R2");
    doOp(3'd1, 0, V2, 0, 0, 0, "R2");
    doOp(3'd1, 0, V3, 0, 0, 0, "R2");
    doOp(3'd1, 0, V4, 0, 0, 0, "R2");
    doOp(3'd1, 0, ZR, 0, 0, 0, "R2");
    // R6 overflow unmasked then masked
    doOp(3'd1, 0, V1, 0, 0, 0, "R6");
    doOp(3'd3, 0, 0, 0, 0, 0, "R6");
    doOp(3'd1, 0, V1, 0, 1, 0, "R6");
    doOp(3'd3, 0, 0, 0, 0, 0, "R6");
    // R9 two-result overflow unmasked then masked
    doOp(3'd5, 0, V2, V3, 0, 0, "R9");
    doOp(3'd5, 0, V2, V3, 1, 0, "R9");
    doOp(3'd3, 0, 0, 0, 0, 0, "R9");
    doOp(3'd3, 1, 0, 0, 0, 0, "R9");
    // R10 restore: low four empty, others claim valid
    doOp(3'd6, 0, 0, 0, 0, 16'h00FF, "R10");
    doOp(3'd6, 0, 0, 0, 0, 16'hFFFF, "R10");
    // R1 init, then R7 pops of empty
    doOp(3'd7, 0, 0, 0, 0, 0, "R1");
    doOp(3'd2, 0, 0, 0, 0, 0, "R7");
    doOp(3'd2, 0, 0, 0, 1, 0, "R7");
    doOp(3'd0, 0, 0, 0, 0, 0, "R7");
    idle(4);
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R2 scoreboard residue actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule